// File: doc/BRIEF.md
# Dual-Lane Saturating Arithmetic Shifter

This block treats one 32-bit data word as two independent signed 16-bit lanes and shifts both lanes by the same signed amount. The amount comes from the low six bits of a separate 16-bit count half-word. Those six bits are read as a two's-complement number from -32 to +31. A positive amount shifts left and saturates. A negative amount shifts right arithmetically, filling with the sign bit. Each lane raises its own flag whenever saturation replaces its value.

The datapath is combinational. A parameter selects whether a single output register is placed behind it. In the default registered variant, a valid strobe captures the data and count. The result, the flags and a valid pulse then appear one clock later and stay unchanged until the next strobe. It is meant to sit behind an operand fetch stage and feed a writeback stage.

Top module: `dual_lane_sat_shift`

## Requirements
- R1: Lane 0 is data bits [15:0] and lane 1 is data bits [31:16]. Each lane's result and flag depend only on that lane and the shared count. Flag bit 0 belongs to lane 0 and flag bit 1 belongs to lane 1.
- R2: Only count bits [5:0] are used, read as a signed value. Bits [15:6] have no effect on the result. For example, a count half-word of 0x5678 acts as a right shift by 8.
- R3: A left shift whose result fits in 16 signed bits is exact, and its flag stays low. This includes negative lanes such as 0xC000 shifted by 1, which gives 0x8000.
- R4: A left shift that loses significant bits saturates the lane. A lane with the sign bit clear becomes 0x7FFF and a lane with the sign bit set becomes 0x8000. The lane's flag is raised. Overflow means that any bit shifted out, or the new sign bit, differs from the original sign bit.
- R5: A lane equal to zero gives zero for every left amount, including 15, 16 and 31, and its flag stays low.
- R6: Left amounts from 16 to 31 saturate every nonzero lane.
- R7: Right shifts are arithmetic and never raise a flag. Amounts from 15 to 32 give 0x0000 for a lane with the sign bit clear and 0xFFFF for a lane with the sign bit set.
- R8: An amount of zero passes both lanes through unchanged, with both flags low.
- R9: In the registered variant, a strobe on `in_valid` gives its result on `out_data`/`out_ovf` one cycle later, with `out_valid` high for that single cycle. Without a strobe the outputs keep their previous values.
- R10: While reset is asserted, and after it is released, `out_data`, `out_ovf` and `out_valid` are all zero until the first strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Two packed signed 16-bit lanes |
| in_count | input | 16 | Count half-word; bits [5:0] give the signed amount |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 32 | Two packed shifted lanes |
| out_ovf | output | 2 | Per-lane saturation flags |

## Verification
On every cycle, the bound checker enforces the following:
- the one-cycle latency and the output hold;
- that a saturated lane holds only 0x7FFF or 0x8000;
- that right shifts never set a flag;
- that a zero amount passes the data through;
- that a zero lane stays zero under left shifts.

Several results can only be shown by the bench's vectors against hand-computed expected words:
- the exact value of each shift;
- the choice of saturation polarity;
- that count bits [15:6] are ignored;
- the wrap of count bits [5:0] into negative amounts;
- the extreme amounts 16, 20 and -32.

// File: rtl/dual_lane_sat_shift_pkg.sv
package dual_lane_sat_shift_pkg;

   localparam int DEF_LANE_W = 16;
   localparam int DEF_LANES  = 2;
   localparam int DEF_CNT_W  = 6;

   typedef enum logic {
      SHIFT_LEFT  = 1'b0,
      SHIFT_RIGHT = 1'b1
   } shift_dir_e;

endpackage

// File: rtl/dls_count_decode.sv
module dls_count_decode
   import dual_lane_sat_shift_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int CNT_W  = 6
) (
   input  logic [HALF_W-1:0] count_half,
   output shift_dir_e        dir,
   output logic [CNT_W-1:0]  mag
);

   logic [CNT_W-1:0] raw;

   always_comb begin
      raw = count_half[CNT_W-1:0];
      if (raw[CNT_W-1]) begin
         dir = SHIFT_RIGHT;
         mag = (~raw) + 1'b1;
      end else begin
         dir = SHIFT_LEFT;
         mag = raw;
      end
   end

endmodule

// File: rtl/dls_lane_shift.sv
module dls_lane_shift
   import dual_lane_sat_shift_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int CNT_W  = 6
) (
   input  logic [LANE_W-1:0] lane_in,
   input  shift_dir_e        dir,
   input  logic [CNT_W-1:0]  mag,
   output logic [LANE_W-1:0] lane_out,
   output logic              sat
);

   localparam int EXT_W = LANE_W + (1 << (CNT_W - 1));
   localparam int TOP_W = EXT_W - LANE_W + 1;

   logic              sgn;
   logic [EXT_W-1:0]  ext;
   logic [EXT_W-1:0]  shl;
   logic [TOP_W-1:0]  top_bits;
   logic [LANE_W-1:0] shr;
   logic [LANE_W-1:0] clamp;
   logic              lost;

   always_comb begin
      sgn      = lane_in[LANE_W-1];
      ext      = {{(EXT_W-LANE_W){sgn}}, lane_in};
      shl      = ext << mag;
      top_bits = shl[EXT_W-1:LANE_W-1];
      lost     = (top_bits != {TOP_W{sgn}});
      shr      = $unsigned($signed(lane_in) >>> mag);
      clamp    = sgn ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}};
      if (dir == SHIFT_RIGHT) begin
         lane_out = shr;
         sat      = 1'b0;
      end else if (lost) begin
         lane_out = clamp;
         sat      = 1'b1;
      end else begin
         lane_out = shl[LANE_W-1:0];
         sat      = 1'b0;
      end
   end

endmodule

// File: rtl/dls_out_stage.sv
module dls_out_stage #(
   parameter int  DATA_W     = 32,
   parameter int  FLAG_W     = 2,
   parameter bit  REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_valid,
   input  logic [DATA_W-1:0] d_data,
   input  logic [FLAG_W-1:0] d_flag,
   output logic              q_valid,
   output logic [DATA_W-1:0] q_data,
   output logic [FLAG_W-1:0] q_flag
);

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_valid <= 1'b0;
               q_data  <= '0;
               q_flag  <= '0;
            end else begin
               q_valid <= d_valid;
               if (d_valid) begin
                  q_data <= d_data;
                  q_flag <= d_flag;
               end
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q_valid = d_valid;
         assign q_data  = d_data;
         assign q_flag  = d_flag;
      end
   endgenerate

endmodule

// File: rtl/dual_lane_sat_shift.sv
module dual_lane_sat_shift
   import dual_lane_sat_shift_pkg::*;
#(
   parameter int LANE_W     = DEF_LANE_W,
   parameter int LANES      = DEF_LANES,
   parameter int CNT_W      = DEF_CNT_W,
   parameter bit REGISTERED = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [LANES*LANE_W-1:0]   in_data,
   input  logic [LANE_W-1:0]         in_count,
   output logic                      out_valid,
   output logic [LANES*LANE_W-1:0]   out_data,
   output logic [LANES-1:0]          out_ovf
);

   localparam int DATA_W = LANES * LANE_W;

   generate
      if (LANE_W < 2) begin : g_bad_lane
         $error("LANE_W must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > LANE_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and LANE_W");
      end
   endgenerate

   shift_dir_e        dir;
   logic [CNT_W-1:0]  mag;
   logic [DATA_W-1:0] shifted;
   logic [LANES-1:0]  sat;

   dls_count_decode #(
      .HALF_W (LANE_W),
      .CNT_W  (CNT_W)
   ) u_decode (
      .count_half (in_count),
      .dir        (dir),
      .mag        (mag)
   );

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         dls_lane_shift #(
            .LANE_W (LANE_W),
            .CNT_W  (CNT_W)
         ) u_lane (
            .lane_in  (in_data[i*LANE_W +: LANE_W]),
            .dir      (dir),
            .mag      (mag),
            .lane_out (shifted[i*LANE_W +: LANE_W]),
            .sat      (sat[i])
         );
      end
   endgenerate

   dls_out_stage #(
      .DATA_W     (DATA_W),
      .FLAG_W     (LANES),
      .REGISTERED (REGISTERED)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_valid (in_valid),
      .d_data  (shifted),
      .d_flag  (sat),
      .q_valid (out_valid),
      .q_data  (out_data),
      .q_flag  (out_ovf)
   );

endmodule

// File: rtl/dual_lane_sat_shift_chk.sv
module dual_lane_sat_shift_chk #(
   parameter int LANE_W     = 16,
   parameter int LANES      = 2,
   parameter int CNT_W      = 6,
   parameter bit REGISTERED = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [LANES*LANE_W-1:0] in_data,
   input logic [LANE_W-1:0]       in_count,
   input logic                    out_valid,
   input logic [LANES*LANE_W-1:0] out_data,
   input logic [LANES-1:0]        out_ovf
);

   localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] NEG_MAX = {1'b1, {(LANE_W-1){1'b0}}};

   generate
      if (REGISTERED) begin : g_seq
         // R9
         latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         // R9
         idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_ovf)));
         // R8
         zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_count[CNT_W-1:0] == '0) |=>
               (out_data == $past(in_data) && out_ovf == '0));
         // R7
         right_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_count[CNT_W-1]) |=> (out_ovf == '0));
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            // R4
            sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
               out_ovf[i] |-> (out_data[i*LANE_W +: LANE_W] == POS_MAX ||
                               out_data[i*LANE_W +: LANE_W] == NEG_MAX));
            // R5
            zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (in_valid && !in_count[CNT_W-1] && in_data[i*LANE_W +: LANE_W] == '0) |=>
                  (out_data[i*LANE_W +: LANE_W] == '0 && !out_ovf[i]));
         end
      end
   endgenerate

endmodule

bind dual_lane_sat_shift dual_lane_sat_shift_chk #(
   .LANE_W     (LANE_W),
   .LANES      (LANES),
   .CNT_W      (CNT_W),
   .REGISTERED (REGISTERED)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .in_count  (in_count),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_ovf   (out_ovf)
);

// File: tb/dual_lane_sat_shift_bench.sv
module dual_lane_sat_shift_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic [15:0] in_count = '0;
   logic        out_valid;
   logic [31:0] out_data;
   logic [1:0]  out_ovf;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dual_lane_sat_shift u_dual_lane_sat_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_count  (in_count),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_ovf   (out_ovf)
   );

   // fields: data, count, expected data, expected flags, requirement number
   localparam int NVEC = 17;
   localparam logic [85:0] VECS [NVEC] = '{
      {32'h2345_6789, 16'h5678, 32'h0023_0067, 2'b00, 4'd2},  // R2 upper bits dropped
      {32'h0123_0002, 16'hFFC5, 32'h2460_0040, 2'b00, 4'd2},  // R2 count 5 with junk
      {32'h0123_0002, 16'h0005, 32'h2460_0040, 2'b00, 4'd3},  // R3 exact left
      {32'hFFFF_C000, 16'h0001, 32'hFFFE_8000, 2'b00, 4'd3},  // R3 exact negative
      {32'h3456_789A, 16'h0004, 32'h7FFF_7FFF, 2'b11, 4'd4},  // R4 positive clamp
      {32'h4567_89AB, 16'h0004, 32'h7FFF_8000, 2'b11, 4'd4},  // R4 mixed clamp
      {32'h4000_0001, 16'h0001, 32'h7FFF_0002, 2'b10, 4'd1},  // R1 lanes independent
      {32'h0000_0002, 16'h000F, 32'h0000_7FFF, 2'b01, 4'd5},  // R5 zero lane, left 15
      {32'h0000_0000, 16'h0010, 32'h0000_0000, 2'b00, 4'd5},  // R5 zero, left 16
      {32'h0123_0002, 16'h0010, 32'h7FFF_7FFF, 2'b11, 4'd6},  // R6 left 16
      {32'h0001_FFFF, 16'h0014, 32'h7FFF_8000, 2'b11, 4'd6},  // R6 left 20
      {32'h0123_0002, 16'hFFFF, 32'h0091_0001, 2'b00, 4'd7},  // R7 right 1
      {32'h4567_89AB, 16'hFFFA, 32'h0115_FE26, 2'b00, 4'd7},  // R7 right 6
      {32'h4567_89AB, 16'hFFF1, 32'h0000_FFFF, 2'b00, 4'd7},  // R7 right 15
      {32'h4567_89AB, 16'hFFF0, 32'h0000_FFFF, 2'b00, 4'd7},  // R7 right 16
      {32'h7FFF_8000, 16'h0020, 32'h0000_FFFF, 2'b00, 4'd7},  // R7 right 32
      {32'h89AB_1234, 16'h0000, 32'h89AB_1234, 2'b00, 4'd8}   // R8 pass through
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] d, input logic [15:0] c);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      in_count = c;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 data", out_data, 32'h0);
      check("R10 flags", {30'h0, out_ovf}, 32'h0);
      check("R10 valid", {31'h0, out_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after release", {out_data[30:0], out_valid}, 32'h0);

      for (int k = 0; k < NVEC; k++) begin
         apply(VECS[k][85:54], VECS[k][53:38]);
         check($sformatf("R%0d vec%0d data", VECS[k][3:0], k), out_data, VECS[k][37:6]);
         check($sformatf("R%0d vec%0d flags", VECS[k][3:0], k),
               {30'h0, out_ovf}, {30'h0, VECS[k][5:4]});
         check($sformatf("R9 vec%0d valid", k), {31'h0, out_valid}, 32'h1);
      end

      // R9 hold: no strobe, changed inputs must not reach the outputs
      apply(32'h4567_89AB, 16'h0004);
      in_data  = 32'h1111_2222;
      in_count = 16'h0003;
      @(negedge clk);
      check("R9 hold data", out_data, 32'h7FFF_8000);
      check("R9 hold flags", {30'h0, out_ovf}, 32'h3);
      check("R9 valid low", {31'h0, out_valid}, 32'h0);

      // R9 back-to-back strobes
      @(negedge clk);
      in_valid = 1'b1; in_data = 32'h0001_0001; in_count = 16'h0002;
      @(negedge clk);
      check("R9 first of pair", out_data, 32'h0004_0004);
      in_data = 32'h0008_FFF8; in_count = 16'hFFFE;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9 second of pair", out_data, 32'h0002_FFFE);

      // R10 reset mid-run clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 mid reset", {out_data[30:0], out_valid}, 32'h0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule